// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers up to fifteen interrupt request lines, numbered 1 upward, and presents a single interrupt number to one processor. A rising edge on a request line is latched as pending. Software can also raise interrupts by writing force bits, and it can remove them through a clear register. The processor acknowledges an interrupt by returning the number it served. A mask for processor 0 selects which interrupts may reach the output. A level register places each enabled interrupt in either a high or a low priority group. When any high group interrupt is active, the low group is hidden.

Software reaches the state through a 32-bit word-access register port in a 256-byte window. There are further mask and force slots for more processors. These slots are storage only and never affect the output. A broadcast register sends chosen request lines into the force bits of every processor slot, in place of the shared pending register.

Top module: `prio_intc`

## Requirements
- R1: Line 0 does not exist. Bit 0 of level, pending, broadcast, every mask slot and every force slot always reads 0, whatever value is written.
- R2: Word offsets are: 0x00 level, 0x04 pending (read only), 0x08 processor-0 force alias, 0x0C clear (reads 0), 0x10 status (reads 0), 0x14 broadcast, 0x40+4*n mask of slot n, and 0x80+4*n force of slot n. Any other offset, and any slot n at or above NUM_CPU, reads 0 and ignores writes.
- R3: The active set is (pending OR force of slot 0) AND mask of slot 0. When an active bit has its level bit at 1, only active bits with level 1 compete for the output.
- R4: Within the group that competes, the highest-numbered bit wins. irq_num carries the winner's number, and carries 0 when nothing is active.
- R5: irq_num is a register. It reflects the register state from the previous clock edge, so it changes one cycle after the edge where a write, request or acknowledge takes effect.
- R6: A 0-to-1 transition on req_i[n] sets pending bit n. When broadcast bit n is 1, the transition instead sets force bit n in every implemented slot and leaves pending unchanged.
- R7: A write to the clear register clears every pending bit and every slot-0 force bit at the positions written as 1. ack_valid with ack_num = n does the same for bit n alone. Force bits in other slots are not touched.
- R8: A write to a slot force register sets the bits given in wdata[15:1] and clears the bits given in wdata[31:17]. The new value is (old OR set) AND NOT clear.
- R9: A write to the alias at 0x08 replaces the slot-0 force bits with wdata[15:1]. The status register at 0x10 reads 0 after any write.
- R10: When a rising request and a clear (by write or by acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R11: Reset sets every register and irq_num to 0.
- R12: Mask and force contents of slots other than 0 have no effect on irq_num.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_LINES+1 | Request lines; bit 0 is ignored |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the word access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_num | input | 4 | Number of the interrupt being acknowledged |
| irq_num | output | 4 | Interrupt presented to the processor; 0 means none |

## Verification
The bench builds the block with all fifteen lines and two processor slots. With fifteen lines, every line can be swept on its own through the pending path. Every ordered pair of lines can also be swept with one member moved to the high group, and the bench computes the expected winner arithmetically. With two slots, one real extra slot can be used to show that it cannot reach the output. Slot indices 2 and above then fall in the absent range, which lets the bench check that writes there are ignored and reads return 0.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int ADDR_W   = 8;
   localparam int DATA_W   = 32;
   localparam int NUM_W    = 4;
   localparam int MAX_SLOT = 16;

   localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_ALIAS  = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_BCAST  = 8'h14;
   localparam logic [1:0]        GRP_MASK   = 2'b01;
   localparam logic [1:0]        GRP_FORCE  = 2'b10;
endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   assign rise = lines & ~prev_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int W     = 16,
   parameter int NUM_W = 4
) (
   input  logic [W-1:0]     active,
   input  logic [W-1:0]     level,
   output logic [NUM_W-1:0] winner
);
   logic [W-1:0] hi_set;
   logic [W-1:0] pick;

   assign hi_set = active & level;
   assign pick   = (|hi_set) ? hi_set : (active & ~level);

   always_comb begin
      winner = '0;
      for (int i = 1; i < W; i++) begin
         if (pick[i]) winner = NUM_W'(i);
      end
   end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_LINES = 15,
   parameter int NUM_CPU   = 4,
   localparam int LW       = NUM_LINES + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [LW-1:0]     rise,
   input  logic              ack_valid,
   input  logic [NUM_W-1:0]  ack_num,
   output logic [LW-1:0]     pend_o,
   output logic [LW-1:0]     frc0_o,
   output logic [LW-1:0]     msk0_o,
   output logic [LW-1:0]     level_o,
   output logic [LW-1:0]     bcast_o
);
   localparam logic [LW-1:0] KEEP = {{NUM_LINES{1'b1}}, 1'b0};

   logic [LW-1:0] pend_q, level_q, bcast_q;
   logic [LW-1:0] msk_arr [MAX_SLOT];
   logic [LW-1:0] frc_arr [MAX_SLOT];

   logic [3:0]    slot;
   logic          wr_level, wr_alias, wr_clear, wr_bcast, wr_mgrp, wr_fgrp;
   logic [LW-1:0] ack_vec, clr_vec, set_pend, set_bc, wlow, whigh;

   assign slot     = addr[5:2];
   assign wr_level = wr_en && addr == OFS_LEVEL;
   assign wr_alias = wr_en && addr == OFS_ALIAS;
   assign wr_clear = wr_en && addr == OFS_CLEAR;
   assign wr_bcast = wr_en && addr == OFS_BCAST;
   assign wr_mgrp  = wr_en && addr[7:6] == GRP_MASK  && addr[1:0] == 2'b00;
   assign wr_fgrp  = wr_en && addr[7:6] == GRP_FORCE && addr[1:0] == 2'b00;

   assign wlow     = wdata[LW-1:0] & KEEP;
   assign whigh    = wdata[16 +: LW] & KEEP;
   assign ack_vec  = ack_valid ? ((LW'(1) << ack_num) & KEEP) : '0;
   assign clr_vec  = (wr_clear ? wlow : '0) | ack_vec;
   assign set_pend = rise & ~bcast_q & KEEP;
   assign set_bc   = rise & bcast_q & KEEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         level_q <= '0;
         bcast_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_vec) | set_pend;
         if (wr_level) level_q <= wlow;
         if (wr_bcast) bcast_q <= wlow;
      end
   end

   for (genvar c = 0; c < MAX_SLOT; c++) begin : g_slot
      if (c < NUM_CPU) begin : g_real
         logic [LW-1:0] msk_q, frc_q, frc_nxt;
         logic          hit_m, hit_f;

         assign hit_m = wr_mgrp && slot == 4'(c);
         assign hit_f = wr_fgrp && slot == 4'(c);

         always_comb begin
            frc_nxt = frc_q;
            if (hit_f) frc_nxt = (frc_q | wlow) & ~whigh;
            if (c == 0) begin
               if (wr_alias) frc_nxt = wlow;
               frc_nxt = frc_nxt & ~clr_vec;
            end
            frc_nxt = frc_nxt | set_bc;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               msk_q <= '0;
               frc_q <= '0;
            end else begin
               if (hit_m) msk_q <= wlow;
               frc_q <= frc_nxt;
            end
         end

         assign msk_arr[c] = msk_q;
         assign frc_arr[c] = frc_q;
      end else begin : g_absent
         assign msk_arr[c] = '0;
         assign frc_arr[c] = '0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr[1:0] == 2'b00) begin
         case (addr)
            OFS_LEVEL: rdata = DATA_W'(level_q);
            OFS_PEND:  rdata = DATA_W'(pend_q);
            OFS_ALIAS: rdata = DATA_W'(frc_arr[0]);
            OFS_BCAST: rdata = DATA_W'(bcast_q);
            default: begin
               if (addr[7:6] == GRP_MASK)  rdata = DATA_W'(msk_arr[slot]);
               if (addr[7:6] == GRP_FORCE) rdata = DATA_W'(frc_arr[slot]);
            end
         endcase
      end
   end

   assign pend_o  = pend_q;
   assign frc0_o  = frc_arr[0];
   assign msk0_o  = msk_arr[0];
   assign level_o = level_q;
   assign bcast_o = bcast_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int NUM_LINES = 15,
   parameter int NUM_CPU   = 4,
   localparam int LW       = NUM_LINES + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LW-1:0]     req_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ack_valid,
   input  logic [NUM_W-1:0]  ack_num,
   output logic [NUM_W-1:0]  irq_num
);
   if (NUM_LINES < 1 || NUM_LINES > 15) begin : g_bad_lines
      $error("prio_intc: NUM_LINES must lie in 1..15");
   end
   if (NUM_CPU < 1 || NUM_CPU > MAX_SLOT) begin : g_bad_cpu
      $error("prio_intc: NUM_CPU must lie in 1..16");
   end

   logic [LW-1:0]    rise_w, pend_w, frc0_w, msk0_w, level_w, bcast_w, act_w;
   logic [NUM_W-1:0] win_w;

   intc_edge #(.W(LW)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(req_i), .rise(rise_w)
   );

   intc_regs #(.NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rise(rise_w), .ack_valid(ack_valid), .ack_num(ack_num),
      .pend_o(pend_w), .frc0_o(frc0_w), .msk0_o(msk0_w), .level_o(level_w),
      .bcast_o(bcast_w)
   );

   assign act_w = (pend_w | frc0_w) & msk0_w;

   intc_prio #(.W(LW), .NUM_W(NUM_W)) u_prio (
      .active(act_w), .level(level_w), .winner(win_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_num <= '0;
      else        irq_num <= win_w;
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int NUM_LINES = 15,
   localparam int LW       = NUM_LINES + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    irq_num,
   input logic [LW-1:0] pend,
   input logic [LW-1:0] frc0,
   input logic [LW-1:0] msk0,
   input logic [LW-1:0] bcast,
   input logic [LW-1:0] rise,
   input logic          ack_valid,
   input logic [3:0]    ack_num,
   input logic [7:0]    addr,
   input logic [31:0]   rdata
);
   p_bit0_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[0] && !frc0[0]);

   p_status_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      addr == 8'h10 |-> rdata == 32'h0);

   p_num_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_num <= 4'(NUM_LINES));

   p_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|((pend | frc0) & msk0)) |=> irq_num != 4'd0);

   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|((pend | frc0) & msk0)) |=> irq_num == 4'd0);

   p_req_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & ~bcast)) |=> (pend & $past(rise & ~bcast)) == $past(rise & ~bcast));

   p_bcast_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & bcast)) |=> (frc0 & $past(rise & bcast)) == $past(rise & bcast));

   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_num != 4'd0 && 32'(ack_num) <= NUM_LINES && !rise[ack_num])
      |=> !pend[$past(ack_num)] && !frc0[$past(ack_num)]);
endmodule

bind prio_intc intc_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_num(irq_num), .pend(pend_w), .frc0(frc0_w),
   .msk0(msk0_w), .bcast(bcast_w), .rise(rise_w), .ack_valid(ack_valid),
   .ack_num(ack_num), .addr(addr), .rdata(rdata)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
   localparam int CLK_P = 10;
   localparam int NL    = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NL:0] req_i = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_num = '0;
   logic [3:0]  irq_num;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   prio_intc #(.NUM_LINES(NL), .NUM_CPU(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ack_valid(ack_valid), .ack_num(ack_num),
      .irq_num(irq_num)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
      addr = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      req_i[n] = 1'b1;
      @(negedge clk);
      req_i[n] = 1'b0;
   endtask

   task automatic ack(input int n);
      @(negedge clk);
      ack_valid = 1'b1; ack_num = 4'(n);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R11: reset state
      chk("R11 irq_num after reset", 32'(irq_num), 0);
      foreach (v[i]) begin end
      for (int a = 0; a < 256; a += 4) begin
         rd(8'(a), v);
         chk("R11 register zero after reset", v, 0);
      end

      // R1: bit 0 never stored
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R1 level bit0", v, 32'h0000_FFFE);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R1 bcast bit0", v, 32'h0000_FFFE);
      wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R1 mask bit0", v, 32'h0000_FFFE);
      wr(8'h08, 32'h0000_0001); rd(8'h08, v); chk("R1 alias bit0", v, 32'h0);
      wr(8'h00, 0); wr(8'h14, 0);

      // R2 / R9: map, status, unmapped, absent slots
      wr(8'h00, 32'h0000_AAAA); rd(8'h00, v); chk("R2 level readback", v, 32'hAAAA);
      wr(8'h44, 32'h0000_5554); rd(8'h44, v); chk("R2 mask slot1", v, 32'h5554);
      wr(8'h80, 32'h0000_0330); rd(8'h08, v); chk("R2 force slot0 via alias", v, 32'h0330);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R9 status reads zero", v, 0);
      rd(8'h0C, v); chk("R2 clear reads zero", v, 0);
      rd(8'h20, v); chk("R2 unmapped 0x20", v, 0);
      rd(8'hC0, v); chk("R2 unmapped 0xC0", v, 0);
      wr(8'h48, 32'h0000_FFFE); rd(8'h48, v); chk("R2 absent mask slot2", v, 0);
      wr(8'h88, 32'h0000_FFFE); rd(8'h88, v); chk("R2 absent force slot2", v, 0);
      wr(8'h00, 0); wr(8'h44, 0); wr(8'h08, 0);
      settle(); settle();
      chk("R9 status write no effect", 32'(irq_num), 0);

      // R6 / R4 / R7: single-line sweep through pending and acknowledge
      wr(8'h40, 32'h0000_FFFE);
      for (int i = 1; i <= NL; i++) begin
         pulse(i); settle();
         rd(8'h04, v); chk("R6 pending set by rising req", v, 32'(1) << i);
         chk("R4 single line number", 32'(irq_num), 32'(i));
         ack(i); settle();
         rd(8'h04, v); chk("R7 ack clears pending", v, 0);
         chk("R7 irq_num after ack", 32'(irq_num), 0);
      end

      // R7: ack clears slot-0 force
      wr(8'h08, 32'(1) << 12); ack(12); rd(8'h08, v);
      chk("R7 ack clears force0", v, 0);

      // R3 / R4: pair sweep across levels
      for (int a = 1; a <= NL; a++) begin
         for (int b = 1; b <= NL; b++) begin
            if (a != b) begin
               wr(8'h08, (32'(1) << a) | (32'(1) << b));
               wr(8'h00, 32'(1) << a);
               settle();
               chk("R3 high level preempts", 32'(irq_num), 32'(a));
               wr(8'h00, 0);
               settle();
               chk("R4 highest number wins", 32'(irq_num), 32'((a > b) ? a : b));
            end
         end
      end
      wr(8'h08, 0);

      // R3: mask blocks
      wr(8'h40, 32'h0000_FFFE & ~(32'(1) << 7));
      wr(8'h08, 32'(1) << 7); settle(); settle();
      chk("R3 masked line not presented", 32'(irq_num), 0);
      wr(8'h40, 32'h0000_FFFE); wr(8'h08, 0); settle(); settle();

      // R5: one-cycle latency
      wr(8'h08, 32'(1) << 5);
      chk("R5 irq_num not yet updated", 32'(irq_num), 0);
      settle();
      chk("R5 irq_num one cycle later", 32'(irq_num), 5);
      wr(8'h08, 0); settle();

      // R12 / R8: slot 1 storage, set/clear halves
      wr(8'h44, 32'h0000_FFFE);
      wr(8'h84, 32'h0000_0800); settle(); settle();
      chk("R12 slot1 force has no effect", 32'(irq_num), 0);
      rd(8'h84, v); chk("R8 slot1 set", v, 32'h0800);
      wr(8'h84, 32'h0008_00F8); rd(8'h84, v); chk("R8 set and clear same write", v, 32'h08F0);
      wr(8'h84, 32'h0001_0001); rd(8'h84, v); chk("R8 bit0 halves ignored", v, 32'h08F0);
      wr(8'h84, 32'h0F00_0000); rd(8'h84, v); chk("R8 clear half", v, 32'h00F0);

      // R6 / R7: broadcast line 9
      wr(8'h14, 32'(1) << 9);
      pulse(9); settle();
      rd(8'h04, v); chk("R6 broadcast leaves pending", v, 0);
      rd(8'h08, v); chk("R6 broadcast sets force0", v, 32'h0200);
      rd(8'h84, v); chk("R6 broadcast sets force1", v, 32'h02F0);
      chk("R6 broadcast line presented", 32'(irq_num), 9);
      wr(8'h0C, 32'h0000_0200);
      rd(8'h08, v); chk("R7 clear write force0", v, 0);
      rd(8'h84, v); chk("R7 clear leaves slot1", v, 32'h02F0);
      settle();
      chk("R7 irq_num after clear", 32'(irq_num), 0);
      wr(8'h14, 0);

      // R10: request wins over clear and over ack
      @(negedge clk);
      req_i[3] = 1'b1; addr = 8'h0C; wdata = 32'h8; wr_en = 1'b1;
      @(negedge clk);
      req_i[3] = 1'b0; wr_en = 1'b0; addr = '0;
      rd(8'h04, v); chk("R10 request beats clear write", v, 32'h0008);
      @(negedge clk);
      req_i[4] = 1'b1; ack_valid = 1'b1; ack_num = 4'd4;
      @(negedge clk);
      req_i[4] = 1'b0; ack_valid = 1'b0;
      rd(8'h04, v); chk("R10 request beats ack", v, 32'h0018);
      wr(8'h0C, 32'h0000_FFFF);
      rd(8'h04, v); chk("R7 clear all pending", v, 0);

      // R11: reset mid-run
      wr(8'h00, 32'h0000_0010); wr(8'h08, 32'h0000_0010); settle();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 irq_num after reset", 32'(irq_num), 0);
      rd(8'h00, v); chk("R11 level cleared", v, 0);
      rd(8'h40, v); chk("R11 mask0 cleared", v, 0);
      rd(8'h84, v); chk("R11 force1 cleared", v, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule